// File: doc/BRIEF.md
# SPI Slave Memory Command Engine

This block sits behind a four-wire SPI slave port and gives an external host byte-wide read and write access to an internal byte array of 2048 locations. Every frame (one low period of chip select) opens with a command byte. Its top five bits pick one of four transfer kinds and its low three bits carry address bits [10:8]. The next byte supplies address bits [7:0]. Writes go either to a run of incrementing addresses or to an arbitrary list of low addresses sharing the upper bits. Reads stream from incrementing addresses or from a list of low addresses that the host sends first.

The SPI pins are oversampled by the system clock through two-stage synchronizers, so the system clock must run at least about eight times faster than SCLK. While command and address bytes arrive, the engine returns a fixed status byte on MISO. Read data is prefetched when a byte completes, so it is ready before the first shift edge of the byte that carries it. For a block read, the host therefore sends one throw-away no-op byte before the data starts. For a list read, the host sends two.

Top module: `spi_mem_engine`

## Requirements
- R1: Outside a frame, and during every command byte, address byte and throw-away byte, MISO carries the status byte 0xA0 (parameter STATUS).
- R2: The port works in SPI mode 0. MOSI is sampled on the rising SCLK edge and MISO changes only after a falling edge. Bytes are 8 bits, most significant bit first.
- R3: Command bits [7:3] are the opcode and bits [2:0] are address bits [10:8]. The byte after the command gives address bits [7:0].
- R4: Opcode 00011 (block write): each byte after the address byte is stored at the start address plus its index, wrapping from 0x7FF to 0x000.
- R5: Opcode 00001 (list write): the bytes after the command alternate between a low address and a data byte. Each data byte is stored at {command bits [2:0], preceding low address}.
- R6: Opcode 00111 (block read): the byte clocked in right after the address returns the status byte. Each following byte returns data from the start address, then from incrementing addresses, wrapping from 0x7FF to 0x000.
- R7: Opcode 00101 (list read): the first low address is always queued. Later bytes other than 0xFF are queued as low addresses. The first 0xFF ends the list, and it and the next byte both return status. The bytes after that return data for the queued addresses in the order given, and then status once the list is used up.
- R8: The list-read queue holds 16 addresses. Addresses beyond the sixteenth are dropped and return no data.
- R9: Raising chip select abandons the transfer, including a partly shifted byte, which is not written. The next frame starts with a command byte.
- R10: A command byte of 0xFF is a no-op, and the next byte is again taken as a command. Any other unlisted opcode makes the rest of the frame have no effect on memory.
- R11: The byte sequence 0x3B, 0x5A, 0xFF, 0xFF returns the contents of address 0x35A during the fourth byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select that frames a transfer |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |

## Verification
The hardest state to reach is a full list-read queue with more addresses still arriving. The read-out must then return exactly the first sixteen entries in order, followed by status. The bench reaches it with one frame that sends eighteen distinct low addresses over a region just filled by a block write. It checks each returned byte against its address-derived value and checks the byte after the sixteenth for status. A second hard case is a frame cut in the middle of a data byte. The bench shifts only three bits, raises chip select, and then reads the location back to show it kept its previous value.

// File: rtl/spi_mem_engine.sv
module spi_mem_engine #(
  parameter int          QDEPTH = 16,
  parameter logic [7:0]  STATUS = 8'hA0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int HW    = AW - 8;
  localparam int QIW   = $clog2(QDEPTH);
  localparam int QW    = $clog2(QDEPTH + 1);
  localparam logic [4:0] OP_BWR = 5'b00011;
  localparam logic [4:0] OP_RWR = 5'b00001;
  localparam logic [4:0] OP_BRD = 5'b00111;
  localparam logic [4:0] OP_RRD = 5'b00101;

  typedef enum logic [3:0] {
    S_CMD, S_BW_ADDR, S_BW_DATA, S_RW_ADDR, S_RW_DATA, S_BR_ADDR, S_BR_GAP,
    S_BR_DATA, S_RR_FIRST, S_RR_LIST, S_RR_GAP, S_RR_OUT, S_SKIP
  } state_t;

  logic [2:0]    sclk_s;
  logic [1:0]    cs_s, mosi_s;
  state_t        st;
  logic [2:0]    bit_cnt;
  logic [7:0]    rx_sr, tx_sr, nxt_tx, lo;
  logic [HW-1:0] hi;
  logic [AW-1:0] ptr, rd_addr, waddr;
  logic [QW-1:0] q_cnt, idx;
  logic [7:0]    q   [QDEPTH];
  logic [7:0]    mem [DEPTH];

  wire active    = ~cs_s[1];
  wire sclk_rise = sclk_s[1] & ~sclk_s[2];
  wire sclk_fall = ~sclk_s[1] & sclk_s[2];
  wire byte_done = active & sclk_rise & (bit_cnt == 3'd7);
  wire [7:0] rx_byte = {rx_sr[6:0], mosi_s[1]};
  wire q_room    = q_cnt < QW'(QDEPTH);
  wire q_push    = byte_done & q_room &
                   (st == S_RR_FIRST || (st == S_RR_LIST && rx_byte != 8'hFF));
  wire we        = byte_done & (st == S_BW_DATA || st == S_RW_DATA);
  wire [7:0] rd_data = mem[rd_addr];

  assign spi_miso = tx_sr[7];
  assign waddr    = (st == S_BW_DATA) ? ptr : {hi, lo};

  always_comb begin
    case (st)
      S_BR_GAP, S_BR_DATA: rd_addr = ptr;
      S_RR_GAP:            rd_addr = {hi, q[0]};
      default:             rd_addr = {hi, q[idx[QIW-1:0]]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '0; cs_s <= '1; mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      cs_s   <= {cs_s[0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end

  always_ff @(posedge clk) if (we) mem[waddr] <= rx_byte;
  always_ff @(posedge clk) if (q_push) q[q_cnt[QIW-1:0]] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_CMD; bit_cnt <= '0; rx_sr <= '0; tx_sr <= STATUS; nxt_tx <= STATUS;
      lo <= '0; hi <= '0; ptr <= '0; q_cnt <= '0; idx <= '0;
    end else if (!active) begin
      st <= S_CMD; bit_cnt <= '0; tx_sr <= STATUS; nxt_tx <= STATUS;
      q_cnt <= '0; idx <= '0;
    end else begin
      if (sclk_rise) begin
        rx_sr   <= rx_byte;
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (sclk_fall) tx_sr <= (bit_cnt == 3'd0) ? nxt_tx : {tx_sr[6:0], 1'b0};
      if (q_push) q_cnt <= q_cnt + QW'(1);
      if (byte_done) begin
        nxt_tx <= STATUS;
        case (st)
          S_CMD: begin
            hi <= rx_byte[2:0];
            case (rx_byte[7:3])
              OP_BWR:  st <= S_BW_ADDR;
              OP_RWR:  st <= S_RW_ADDR;
              OP_BRD:  st <= S_BR_ADDR;
              OP_RRD:  st <= S_RR_FIRST;
              default: st <= (rx_byte == 8'hFF) ? S_CMD : S_SKIP;
            endcase
          end
          S_BW_ADDR: begin ptr <= {hi, rx_byte}; st <= S_BW_DATA; end
          S_BW_DATA: ptr <= ptr + AW'(1);
          S_RW_ADDR: begin lo <= rx_byte; st <= S_RW_DATA; end
          S_RW_DATA: st <= S_RW_ADDR;
          S_BR_ADDR: begin ptr <= {hi, rx_byte}; st <= S_BR_GAP; end
          S_BR_GAP, S_BR_DATA: begin
            nxt_tx <= rd_data; ptr <= ptr + AW'(1); st <= S_BR_DATA;
          end
          S_RR_FIRST: st <= S_RR_LIST;
          S_RR_LIST: if (rx_byte == 8'hFF) st <= S_RR_GAP;
          S_RR_GAP: begin nxt_tx <= rd_data; idx <= QW'(1); st <= S_RR_OUT; end
          S_RR_OUT: if (idx < q_cnt) begin nxt_tx <= rd_data; idx <= idx + QW'(1); end
          default: ;
        endcase
      end
    end

  a_r8_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QW'(QDEPTH));
  a_r7_index_in_list: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RR_OUT) |-> (idx <= q_cnt));
  a_r9_abort_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s[1] |=> (st == S_CMD && bit_cnt == 3'd0));
  a_r2_miso_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && sclk_s[1] && sclk_s[2]) |-> $stable(spi_miso));
  a_r1_idle_status: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (spi_miso == STATUS[7]));
endmodule

// File: tb/spi_mem_engine_tb.sv
module spi_mem_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam logic [7:0] ST = 8'hA0;
  localparam logic [18:0] VEC [8] = '{
    {11'h35A, 8'hC3}, {11'h000, 8'h11}, {11'h0FF, 8'h22}, {11'h100, 8'h33},
    {11'h2AB, 8'h44}, {11'h4CD, 8'h55}, {11'h7FF, 8'h66}, {11'h5A5, 8'h77}};

  logic clk = 0, rst_n = 0, spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0;
  logic spi_miso;
  logic [7:0] txb [48];
  logic [7:0] rxb [48];
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mem_engine u_dut (.clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic frame(input int n, input int last_bits);
    spi_cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      logic [7:0] r = '0;
      int nb = (i == n-1) ? last_bits : 8;
      for (int b = 0; b < nb; b++) begin
        spi_mosi = txb[i][7-b];
        repeat (HALF) @(negedge clk);
        r = {r[6:0], spi_miso};
        spi_sclk = 1;
        repeat (HALF) @(negedge clk);
        spi_sclk = 0;
      end
      rxb[i] = r;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1;
    repeat (2*HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 idle miso after reset", {7'd0, spi_miso}, {7'd0, ST[7]});

    // Table: list write of one byte, then block read (R3, R5, R6, R11)
    for (int v = 0; v < 8; v++) begin
      logic [10:0] a = VEC[v][18:8];
      logic [7:0]  d = VEC[v][7:0];
      txb[0] = {5'b00001, a[10:8]}; txb[1] = a[7:0]; txb[2] = d;
      frame(3, 8);
      chk("R1 status on command byte", rxb[0], ST);
      chk("R1 status on address byte", rxb[1], ST);
      txb[0] = {5'b00111, a[10:8]}; txb[1] = a[7:0]; txb[2] = 8'hFF; txb[3] = 8'hFF;
      frame(4, 8);
      chk("R6 throw-away byte is status", rxb[2], ST);
      if (a == 11'h35A) begin
        chk("R11 sequence bytes 0x3B 0x5A", {txb[0] ^ 8'h3B} | {txb[1] ^ 8'h5A}, 8'h00);
        chk("R11 fourth byte returns 0x35A", rxb[3], d);
      end else chk("R3 R6 block read data", rxb[3], d);
    end

    // R4/R6 wrap across 0x7FF
    txb[0] = 8'h1F; txb[1] = 8'hFE; txb[2] = 8'hAA; txb[3] = 8'hBB; txb[4] = 8'hCC; txb[5] = 8'hDD;
    frame(6, 8);
    txb[0] = 8'h3F; txb[1] = 8'hFE;
    for (int i = 2; i < 7; i++) txb[i] = 8'hFF;
    frame(7, 8);
    chk("R4 R6 data at 0x7FE", rxb[3], 8'hAA);
    chk("R4 R6 data at 0x7FF", rxb[4], 8'hBB);
    chk("R4 R6 wrap to 0x000", rxb[5], 8'hCC);
    chk("R4 R6 wrap to 0x001", rxb[6], 8'hDD);

    // R5 multi-pair list write, R7 list read order
    txb[0] = 8'h0B; txb[1] = 8'h10; txb[2] = 8'h11; txb[3] = 8'h20; txb[4] = 8'h22;
    frame(5, 8);
    txb[0] = 8'h2B; txb[1] = 8'h20; txb[2] = 8'h10;
    for (int i = 3; i < 8; i++) txb[i] = 8'hFF;
    frame(8, 8);
    chk("R7 status on first 0xFF", rxb[3], ST);
    chk("R7 status on second 0xFF", rxb[4], ST);
    chk("R5 R7 first listed 0x320", rxb[5], 8'h22);
    chk("R5 R7 second listed 0x310", rxb[6], 8'h11);
    chk("R7 status after list", rxb[7], ST);

    // R8 queue overflow
    txb[0] = 8'h18; txb[1] = 8'h00;
    for (int i = 0; i < 18; i++) txb[2+i] = 8'h30 + 8'(i);
    frame(20, 8);
    txb[0] = 8'h28;
    for (int i = 0; i < 18; i++) txb[1+i] = 8'(i);
    for (int i = 19; i < 38; i++) txb[i] = 8'hFF;
    frame(38, 8);
    for (int k = 0; k < 16; k++) chk("R8 queued entry data", rxb[21+k], 8'h30 + 8'(k));
    chk("R8 dropped entries give status", rxb[37], ST);

    // R9 abort mid-byte
    txb[0] = 8'h08; txb[1] = 8'h40; txb[2] = 8'h77;
    frame(3, 8);
    txb[0] = 8'h18; txb[1] = 8'h40; txb[2] = 8'h00;
    frame(3, 3);
    txb[0] = 8'h38; txb[1] = 8'h40; txb[2] = 8'hFF; txb[3] = 8'hFF;
    frame(4, 8);
    chk("R9 partial byte not written", rxb[3], 8'h77);

    // R10 no-op command then write; unknown opcode ignored
    txb[0] = 8'hFF; txb[1] = 8'h08; txb[2] = 8'h40; txb[3] = 8'h99;
    frame(4, 8);
    chk("R10 status on no-op", rxb[0], ST);
    txb[0] = 8'h50; txb[1] = 8'h40; txb[2] = 8'h11; txb[3] = 8'h40; txb[4] = 8'h12;
    frame(5, 8);
    chk("R10 unknown opcode returns status", rxb[4], ST);
    txb[0] = 8'h38; txb[1] = 8'h40; txb[2] = 8'hFF; txb[3] = 8'hFF;
    frame(4, 8);
    chk("R10 write after no-op, unknown ignored", rxb[3], 8'h99);
    chk("R2 idle miso after frames", {7'd0, spi_miso}, {7'd0, ST[7]});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule